// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Model

This block is a synthesizable model of a byte-wide dynamic memory device. It receives each address in two halves over one shared set of address pins. An active-low row strobe captures the row half. An active-low column strobe then captures the column half, and the byte at that row and column is read or written. The array has rows of bytes. Its depth is set by two parameters, so simulation can use a small array while the full device of 4096 rows by 512 bytes remains reachable.

The model does not include charge decay. Instead, each row has an age counter. A row is flagged as stale once it has gone a parameterised number of clock cycles without a refresh. A refresh is a row-strobe-only cycle: the row strobe falls, the column strobe stays high, and the row strobe rises again. It renews the latched row and clears that row's flag.

All pins are sampled on the rising clock edge. Strobe edges are found by comparing each sample with the one before it. The interface has no back-pressure. A read result appears on the data output for as long as the column strobe stays low, and the output is zero at every other time.

Top module: `mux_addr_dram`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the data output is zero and no row is flagged stale.
- R2: A falling row strobe captures the row from all address pins. The address pins may change while the row strobe stays low, and every access in that cycle still uses the captured row.
- R3: A falling column strobe while the row strobe is low captures the column from the low COL_BITS address pins. The upper pins have no effect on which byte is accessed.
- R4: An access with chip select low and write-enable low stores the data input at the captured row and column.
- R5: An access with chip select low and write-enable high puts the addressed byte on the data output from the clock edge that samples the column strobe falling. The byte stays there until an edge samples the column strobe high, and the output is zero at all other times.
- R6: With chip select high, a column access neither writes the array nor drives the data output.
- R7: A column strobe that falls while the row strobe is high performs no access: it neither writes nor reads.
- R8: Several column strobe pulses during one row strobe low period each access a different column of the same captured row.
- R9: A row becomes stale exactly REFRESH_CYCLES clock cycles after its last refresh, or after reset. It then stays stale until it is refreshed.
- R10: A row-strobe-only cycle refreshes the captured row when the row strobe rises. Only that row's stale flag clears.
- R11: A row strobe period that contains a column access does not refresh its row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ROW_BITS | Shared address pins: row half, then column half (low COL_BITS) |
| ras_n_i | input | 1 | Row address strobe, active low |
| cas_n_i | input | 1 | Column address strobe, active low |
| cs_n_i | input | 1 | Chip select, active low |
| we_n_i | input | 1 | Write enable, active low (high means read) |
| din_i | input | 8 | Write data |
| dout_o | output | 8 | Read data, zero when no read is being held |
| stale_o | output | 2**ROW_BITS | Per-row stale flag, bit i for row i |

## Verification
If the row latch were captured at the wrong time, or the column were taken from the wrong pins, a read would return a byte from another location. That wrong byte would appear on the data output one clock after the column strobe falls. If the read hold were wrong, the output would stay non-zero on the edge after the column strobe rises, or it would lose its value early. A refresh that reaches the wrong row, or that is triggered by a cycle containing a column access, would show in the stale vector on the clock after the row strobe rises. An age counter off by one would move the first stale flag one cycle earlier or later than REFRESH_CYCLES after reset.

// File: rtl/mxd_pkg.sv
package mxd_pkg;
  localparam int CELL_W = 8;
  typedef logic [CELL_W-1:0] cell_t;
endpackage

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl #(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ROW_BITS-1:0] addr_i,
  input  logic                ras_n_i,
  input  logic                cas_n_i,
  input  logic                cs_n_i,
  input  logic                we_n_i,
  output logic [ROW_BITS-1:0] row_o,
  output logic [COL_BITS-1:0] col_o,
  output logic                wr_en_o,
  output logic                rd_en_o,
  output logic                rd_hold_o,
  output logic                rf_en_o
);
  logic ras_d, cas_d, active_q, cas_seen_q, hold_q;
  logic [ROW_BITS-1:0] row_q;
  logic ras_fall, ras_rise, cas_fall, access;

  assign ras_fall = ras_d & ~ras_n_i;
  assign ras_rise = ~ras_d & ras_n_i;
  assign cas_fall = cas_d & ~cas_n_i;
  assign access   = cas_fall & active_q & ~ras_n_i;

  assign row_o     = row_q;
  assign col_o     = addr_i[COL_BITS-1:0];
  assign wr_en_o   = access & ~cs_n_i & ~we_n_i;
  assign rd_en_o   = access & ~cs_n_i & we_n_i;
  assign rd_hold_o = hold_q;
  assign rf_en_o   = ras_rise & active_q & ~cas_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_d      <= 1'b1;
      cas_d      <= 1'b1;
      active_q   <= 1'b0;
      cas_seen_q <= 1'b0;
      hold_q     <= 1'b0;
      row_q      <= '0;
    end else begin
      ras_d <= ras_n_i;
      cas_d <= cas_n_i;
      if (ras_fall) begin
        row_q      <= addr_i;
        active_q   <= 1'b1;
        cas_seen_q <= 1'b0;
      end else if (ras_n_i) begin
        active_q <= 1'b0;
      end else if (access) begin
        cas_seen_q <= 1'b1;
      end
      if (rd_en_o)                hold_q <= 1'b1;
      else if (cas_n_i | ras_n_i) hold_q <= 1'b0;
    end
  end

  // R2
  row_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_fall |=> $stable(row_q));
  // R7
  no_access_ras_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ras_n_i |-> !(wr_en_o || rd_en_o));
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array
  import mxd_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 3
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ROW_BITS-1:0] row,
  input  logic [COL_BITS-1:0] col,
  input  cell_t               wdata,
  output cell_t               rdata
);
  localparam int IDX_W = ROW_BITS + COL_BITS;
  localparam int DEPTH = 1 << IDX_W;

  cell_t mem [DEPTH];
  cell_t rdata_q;
  logic [IDX_W-1:0] idx;

  assign idx   = {row, col};
  assign rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
    if (rd_en) rdata_q  <= mem[idx];
  end
endmodule

// File: rtl/dram_refresh_tracker.sv
module dram_refresh_tracker #(
  parameter int ROW_BITS       = 4,
  parameter int REFRESH_CYCLES = 1000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rf_en,
  input  logic [ROW_BITS-1:0]    rf_row,
  output logic [(1<<ROW_BITS)-1:0] stale_o
);
  localparam int ROWS  = 1 << ROW_BITS;
  localparam int AGE_W = $clog2(REFRESH_CYCLES + 1);
  localparam logic [AGE_W-1:0] LIM = AGE_W'(REFRESH_CYCLES);

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    logic [AGE_W-1:0] age_q;
    logic hit;
    assign hit        = rf_en && (rf_row == ROW_BITS'(i));
    assign stale_o[i] = (age_q == LIM);

    always_ff @(posedge clk) begin
      if (!rst_n)            age_q <= '0;
      else if (hit)          age_q <= '0;
      else if (age_q != LIM) age_q <= age_q + 1'b1;
    end

    // R10
    refresh_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !stale_o[i]);
    // R9
    stale_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stale_o[i] && !hit |=> stale_o[i]);
  end
endmodule

// File: rtl/mux_addr_dram.sv
module mux_addr_dram
  import mxd_pkg::*;
#(
  parameter int ROW_BITS       = 4,
  parameter int COL_BITS       = 3,
  parameter int REFRESH_CYCLES = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ROW_BITS-1:0]      addr_i,
  input  logic                     ras_n_i,
  input  logic                     cas_n_i,
  input  logic                     cs_n_i,
  input  logic                     we_n_i,
  input  logic [CELL_W-1:0]        din_i,
  output logic [CELL_W-1:0]        dout_o,
  output logic [(1<<ROW_BITS)-1:0] stale_o
);
  logic [ROW_BITS-1:0] row;
  logic [COL_BITS-1:0] col;
  logic wr_en, rd_en, rd_hold, rf_en;
  cell_t rdata;

  dram_strobe_ctrl #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i), .cs_n_i(cs_n_i), .we_n_i(we_n_i),
    .row_o(row), .col_o(col), .wr_en_o(wr_en), .rd_en_o(rd_en),
    .rd_hold_o(rd_hold), .rf_en_o(rf_en));

  dram_cell_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_array (
    .clk(clk), .wr_en(wr_en), .rd_en(rd_en), .row(row), .col(col),
    .wdata(din_i), .rdata(rdata));

  dram_refresh_tracker #(.ROW_BITS(ROW_BITS), .REFRESH_CYCLES(REFRESH_CYCLES)) u_refresh (
    .clk(clk), .rst_n(rst_n), .rf_en(rf_en), .rf_row(row), .stale_o(stale_o));

  assign dout_o = rd_hold ? rdata : '0;

  // R5
  dout_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_n_i |=> dout_o == '0);
  // R6
  cs_gates_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |-> !(wr_en || rd_en));
  // R4
  rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, rd_en}));
endmodule

// File: tb/test_mux_addr_dram.sv
module test_mux_addr_dram;
  localparam int RB = 4, CB = 3, LIM = 60, ROWS = 1 << RB;
  localparam logic [ROWS-1:0] ALL = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [RB-1:0] addr = '0;
  logic ras_n = 1'b1, cas_n = 1'b1, cs_n = 1'b1, we_n = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout_o;
  logic [ROWS-1:0] stale_o;

  always #2.5 clk = ~clk;

  mux_addr_dram #(.ROW_BITS(RB), .COL_BITS(CB), .REFRESH_CYCLES(LIM)) i_mux_addr_dram (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .ras_n_i(ras_n), .cas_n_i(cas_n),
    .cs_n_i(cs_n), .we_n_i(we_n), .din_i(din), .dout_o(dout_o), .stale_o(stale_o));

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  event mon_ev;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(mon_ev);
    if (exp_q.size() > 0) begin
      string t;
      logic [7:0] e;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      chk(t, {24'd0, dout_o}, {24'd0, e});
    end
  end

  task automatic ras_open(input logic [RB-1:0] r);
    @(negedge clk);
    addr  = r;
    ras_n = 1'b0;
    @(negedge clk);
    addr  = ~r;
  endtask

  task automatic ras_close();
    ras_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cas_op(input logic [RB-1:0] pins, input bit wr, input bit cs,
                        input logic [7:0] d, input logic [7:0] exp, input string req);
    addr  = pins;
    we_n  = !wr;
    cs_n  = !cs;
    din   = d;
    cas_n = 1'b0;
    @(negedge clk);
    if (!wr) begin
      exp_q.push_back(exp);
      tag_q.push_back(req);
      -> mon_ev;
    end
    cas_n = 1'b1;
    cs_n  = 1'b1;
    we_n  = 1'b1;
    @(negedge clk);
    chk({req, " R5 zero after CAS high"}, {24'd0, dout_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 dout in reset", {24'd0, dout_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dout after reset", {24'd0, dout_o}, 0);
    chk("R1 stale after reset", stale_o, 0);
    repeat (LIM - 10) @(negedge clk);
    chk("R9 not stale early", stale_o, 0);

    // R3 R4: write row 3 col 5 with upper pins set
    ras_open(4'd3);
    cas_op(4'b1101, 1, 1, 8'hA5, 8'h00, "R4 write");
    ras_close();
    ras_open(4'd3);
    cas_op(4'b0101, 0, 1, 8'h00, 8'hA5, "R3 upper pins ignored");
    ras_close();

    // R2: row 9 write, garbage on pins after RAS fall
    ras_open(4'd9);
    cas_op(4'b0101, 1, 1, 8'h3C, 8'h00, "R2 write");
    ras_close();
    ras_open(4'd9);
    cas_op(4'b0101, 0, 1, 8'h00, 8'h3C, "R2 latched row 9");
    ras_close();
    ras_open(4'd3);
    cas_op(4'b0101, 0, 1, 8'h00, 8'hA5, "R2 row 3 intact");
    ras_close();

    // R8: page mode on row 7
    ras_open(4'd7);
    for (int c = 0; c < 4; c++)
      cas_op(RB'(c), 1, 1, 8'h10 + 8'(c), 8'h00, "R8 write");
    for (int c = 3; c >= 0; c--)
      cas_op(RB'(c), 0, 1, 8'h00, 8'h10 + 8'(c), "R8 page read");
    ras_close();

    // R6: chip select high
    ras_open(4'd3);
    cas_op(4'd5, 1, 0, 8'h11, 8'h00, "R6 write");
    cas_op(4'd5, 0, 0, 8'h00, 8'h00, "R6 read deselected");
    cas_op(4'd5, 0, 1, 8'h00, 8'hA5, "R6 data kept");
    ras_close();

    // R7: CAS with RAS high
    cas_op(4'd5, 1, 1, 8'h77, 8'h00, "R7 write");
    cas_op(4'd5, 0, 1, 8'h00, 8'h00, "R7 read no RAS");
    ras_open(4'd3);
    cas_op(4'd5, 0, 1, 8'h00, 8'hA5, "R7 data kept");
    ras_close();

    // R9: everything stale
    repeat (LIM + 5) @(negedge clk);
    chk("R9 all stale", stale_o, ALL);

    // R10: RAS-only refresh of row 2
    ras_open(4'd2);
    ras_close();
    chk("R10 row 2 refreshed", stale_o, ALL & ~(ROWS'(1) << 2));

    // R11: cycle with access does not refresh row 7
    ras_open(4'd7);
    cas_op(4'd0, 0, 1, 8'h00, 8'h10, "R11 read");
    ras_close();
    chk("R11 row 7 still stale", stale_o, ALL & ~(ROWS'(1) << 2));

    repeat (LIM + 5) @(negedge clk);
    chk("R9 row 2 stale again", stale_o, ALL);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule